// File: doc/BRIEF.md
# Latched-Level GPIO Interrupt Controller

A register-mapped controller for a bank of twelve general-purpose pins. Software drives each pin's output value and output enable, reads back the synchronised pin levels, and writes a 32-bit pin-mux word that leaves the block on its own output for routing logic elsewhere in the chip. Every pin can also raise a level-sensitive interrupt. The polarity of each pin's interrupt can be programmed.

A qualified level sets a sticky status bit. Software clears a status bit by writing a one to it. A per-pin enable mask gates the status bits, and every enabled, pending bit is ORed into one interrupt line. Status keeps latching while its enable is off, so unmasking a pin shows its history at once.

If the source level is still active when software clears a bit, the clear holds for exactly one cycle and the bit sets again on the next. A handler must remove the cause before it acknowledges the bit. Access uses a simple synchronous bus with an address, a write strobe with data, and a read strobe. Read data is registered.

Top module: `lvl_gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero. `pin_out`, `pin_oe` and `mux_word` are zero and `irq` is low.
- R2: The output-value register (offset 0x00) drives `pin_out`. The output-enable register (offset 0x04) drives `pin_oe`. Both read back what was written, limited to bits 11:0.
- R3: The input register (offset 0x08) returns the pin levels after a two-flop synchroniser. A pin change made just before clock edge k is returned by a read sampled at edge k+2, and not by reads sampled at edges k or k+1.
- R4: The polarity bit of pin n is bit 4*(n mod 8). For pins 0 to 7 it is in the register at offset 0x10, and for pins 8 to 11 it is in the register at offset 0x18. A value of 0 makes the interrupt active-high and a value of 1 makes it active-low. All other bits of these two registers read zero.
- R5: A status bit (register at offset 0x0C) sets on the clock edge after its synchronised, polarity-qualified level is active, and then stays set. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R6: If the qualified level is still active when its status bit is cleared, the bit reads 0 in the cycle just after the clear and is set again one cycle later. When a clear and a new set fall on the same edge, the clear wins.
- R7: In the enable register (offset 0x14), a 1 unmasks a pin. `irq` is the OR of (status AND enable). It follows an enable write without added delay. A masked pin still latches its status.
- R8: The mux register (offset 0x1C) is a full 32-bit read/write word and drives `mux_word`.
- R9: Register bits above pin 11 read zero and ignore writes. Any address outside the eight offsets reads zero, and writes to such an address change nothing.
- R10: `bus_rdata` is loaded on the clock edge where `bus_rd` is high. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output values to the pads |
| pin_oe | output | 12 | Output enables to the pads |
| mux_word | output | 32 | Pin-mux control word |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the one-cycle hole after a clear while the source stays active. The bench makes the level active, writes the clear, and issues a read on the very next edge; that read must return the bit as zero. A read one cycle later must show the bit set again.

The same back-to-back read timing measures the synchroniser depth. The pin is changed in the same cycle as the first of three consecutive reads of the input register.

Polarity is flipped to active-low while the pins are held at zero. This shows that the stride-4 field positions in both type registers map to the right pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned BUS_DW        = 32;
  localparam int unsigned PINS_PER_TYPE = 8;
  localparam int unsigned TYPE_STRIDE   = 4;

  localparam logic [7:0] OFS_DOUT   = 8'h00;
  localparam logic [7:0] OFS_DOE    = 8'h04;
  localparam logic [7:0] OFS_DIN    = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_POL_LO = 8'h10;
  localparam logic [7:0] OFS_IEN    = 8'h14;
  localparam logic [7:0] OFS_POL_HI = 8'h18;
  localparam logic [7:0] OFS_MUX    = 8'h1C;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DOUT,
    SEL_DOE,
    SEL_DIN,
    SEL_STAT,
    SEL_POL_LO,
    SEL_IEN,
    SEL_POL_HI,
    SEL_MUX
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [7:0] a);
    case (a)
      OFS_DOUT:   return SEL_DOUT;
      OFS_DOE:    return SEL_DOE;
      OFS_DIN:    return SEL_DIN;
      OFS_STAT:   return SEL_STAT;
      OFS_POL_LO: return SEL_POL_LO;
      OFS_IEN:    return SEL_IEN;
      OFS_POL_HI: return SEL_POL_HI;
      OFS_MUX:    return SEL_MUX;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_core_n = stage_q[1];

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [BUS_DW-1:0] wdata,
  output logic [NPINS-1:0]  dout,
  output logic [NPINS-1:0]  doe,
  output logic [NPINS-1:0]  pol,
  output logic [NPINS-1:0]  ien,
  output logic [BUS_DW-1:0] mux,
  output logic [BUS_DW-1:0] pol_lo_rd,
  output logic [BUS_DW-1:0] pol_hi_rd
);

  localparam int unsigned LO_N = (NPINS < PINS_PER_TYPE) ? NPINS : PINS_PER_TYPE;

  logic [NPINS-1:0]  dout_q, dout_d;
  logic [NPINS-1:0]  doe_q, doe_d;
  logic [NPINS-1:0]  ien_q, ien_d;
  logic [NPINS-1:0]  pol_q, pol_d;
  logic [BUS_DW-1:0] mux_q, mux_d;
  logic [NPINS-1:0]  pol_we;
  logic [NPINS-1:0]  pol_wv;
  logic              dout_en, doe_en, ien_en, mux_en;

  assign dout_en = wr_en && (sel == SEL_DOUT);
  assign doe_en  = wr_en && (sel == SEL_DOE);
  assign ien_en  = wr_en && (sel == SEL_IEN);
  assign mux_en  = wr_en && (sel == SEL_MUX);

  for (genvar i = 0; i < NPINS; i++) begin : g_pol
    if (i < PINS_PER_TYPE) begin : g_lo
      assign pol_we[i] = wr_en && (sel == SEL_POL_LO);
      assign pol_wv[i] = wdata[TYPE_STRIDE*i];
    end else begin : g_hi
      assign pol_we[i] = wr_en && (sel == SEL_POL_HI);
      assign pol_wv[i] = wdata[TYPE_STRIDE*(i-PINS_PER_TYPE)];
    end
  end

  always_comb begin
    dout_d = dout_en ? wdata[NPINS-1:0] : dout_q;
    doe_d  = doe_en  ? wdata[NPINS-1:0] : doe_q;
    ien_d  = ien_en  ? wdata[NPINS-1:0] : ien_q;
    mux_d  = mux_en  ? wdata            : mux_q;
    for (int i = 0; i < NPINS; i++) begin
      pol_d[i] = pol_we[i] ? pol_wv[i] : pol_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      doe_q  <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
      mux_q  <= '0;
    end else begin
      if (dout_en)   dout_q <= dout_d;
      if (doe_en)    doe_q  <= doe_d;
      if (ien_en)    ien_q  <= ien_d;
      if (mux_en)    mux_q  <= mux_d;
      if (|pol_we)   pol_q  <= pol_d;
    end
  end

  always_comb begin
    pol_lo_rd = '0;
    pol_hi_rd = '0;
    for (int i = 0; i < LO_N; i++) begin
      pol_lo_rd[TYPE_STRIDE*i] = pol_q[i];
    end
    for (int i = PINS_PER_TYPE; i < NPINS; i++) begin
      pol_hi_rd[TYPE_STRIDE*(i-PINS_PER_TYPE)] = pol_q[i];
    end
  end

  assign dout = dout_q;
  assign doe  = doe_q;
  assign pol  = pol_q;
  assign ien  = ien_q;
  assign mux  = mux_q;

endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
  parameter int unsigned NPINS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] ien,
  output logic [NPINS-1:0] act,
  output logic [NPINS-1:0] status,
  output logic             irq
);

  logic [NPINS-1:0] stat_q, stat_d;

  assign act = lvl ^ pol;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      stat_d[i] = clr[i] ? 1'b0 : (stat_q[i] | act[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
  assign irq    = |(stat_q & ien);

endmodule

// File: rtl/lvl_gpio_irq_ctrl.sv
module lvl_gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 12,
  parameter int unsigned AW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [BUS_DW-1:0] mux_word,
  output logic              irq
);

  logic              rst_core_n;
  logic [7:0]        addr8;
  reg_sel_e          sel;
  logic [NPINS-1:0]  lvl_sync;
  logic [NPINS-1:0]  pol;
  logic [NPINS-1:0]  ien;
  logic [NPINS-1:0]  act;
  logic [NPINS-1:0]  status;
  logic [NPINS-1:0]  clr_vec;
  logic [BUS_DW-1:0] pol_lo_rd, pol_hi_rd;
  logic [BUS_DW-1:0] rd_val;
  logic [BUS_DW-1:0] rdata_q, rdata_d;

  assign addr8   = 8'(bus_addr);
  assign sel     = decode_addr(addr8);
  assign clr_vec = (bus_wr && (sel == SEL_STAT)) ? bus_wdata[NPINS-1:0] : '0;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  gpio_sync2 #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pin_in),
    .q     (lvl_sync)
  );

  gpio_regfile #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (bus_wr),
    .sel       (sel),
    .wdata     (bus_wdata),
    .dout      (pin_out),
    .doe       (pin_oe),
    .pol       (pol),
    .ien       (ien),
    .mux       (mux_word),
    .pol_lo_rd (pol_lo_rd),
    .pol_hi_rd (pol_hi_rd)
  );

  gpio_irq_latch #(.NPINS(NPINS)) u_latch (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .lvl    (lvl_sync),
    .pol    (pol),
    .clr    (clr_vec),
    .ien    (ien),
    .act    (act),
    .status (status),
    .irq    (irq)
  );

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_DOUT:   rd_val[NPINS-1:0] = pin_out;
      SEL_DOE:    rd_val[NPINS-1:0] = pin_oe;
      SEL_DIN:    rd_val[NPINS-1:0] = lvl_sync;
      SEL_STAT:   rd_val[NPINS-1:0] = status;
      SEL_IEN:    rd_val[NPINS-1:0] = ien;
      SEL_POL_LO: rd_val            = pol_lo_rd;
      SEL_POL_HI: rd_val            = pol_hi_rd;
      SEL_MUX:    rd_val            = mux_word;
      default:    rd_val            = '0;
    endcase
    rdata_d = rd_val;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 12,
  parameter int unsigned AW    = 6
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [BUS_DW-1:0] bus_rdata,
  input logic [NPINS-1:0]  pin_oe,
  input logic [NPINS-1:0]  status,
  input logic [NPINS-1:0]  ien,
  input logic [NPINS-1:0]  act,
  input logic              irq
);

  logic [7:0] a8;
  logic       wr_stat, wr_doe, rd_narrow;

  assign a8        = 8'(bus_addr);
  assign wr_stat   = bus_wr && (a8 == OFS_STAT);
  assign wr_doe    = bus_wr && (a8 == OFS_DOE);
  assign rd_narrow = bus_rd && (a8 != OFS_POL_LO) && (a8 != OFS_POL_HI) && (a8 != OFS_MUX);

  // R7: masked-out status never drives the line
  a_r7_irq_off_when_masked: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((status & ien) == '0) |-> !irq);

  // R7: an enabled pending pin always drives the line
  a_r7_irq_on_when_pending: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((status & ien) != '0) |-> irq);

  // R6: a clear wins over a same-edge set
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(wr_stat) |-> ((status & $past(bus_wdata[NPINS-1:0])) == '0));

  // R5: a status bit rises only after an active qualified level
  a_r5_set_needs_level: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((status & ~$past(status) & ~$past(act)) == '0));

  // R2: output enables change only through their register
  a_r2_oe_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_doe |=> $stable(pin_oe));

  // R9: pin-wide registers read zero above the pin count
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    $past(rd_narrow) |-> (bus_rdata[BUS_DW-1:NPINS] == '0));

  // R10: read data holds without a read strobe
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind lvl_gpio_irq_ctrl gpio_irq_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .pin_oe     (pin_oe),
  .status     (status),
  .ien        (ien),
  .act        (act),
  .irq        (irq)
);

// File: tb/lvl_gpio_irq_ctrl_bench.sv
module lvl_gpio_irq_ctrl_bench;
  import gpio_irq_pkg::*;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NPINS      = 12;
  localparam int unsigned AW         = 6;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic              clk;
  logic              rst_n;
  logic [AW-1:0]     bus_addr;
  logic              bus_wr;
  logic [31:0]       bus_wdata;
  logic              bus_rd;
  logic [31:0]       bus_rdata;
  logic [NPINS-1:0]  pin_in;
  logic [NPINS-1:0]  pin_out;
  logic [NPINS-1:0]  pin_oe;
  logic [31:0]       mux_word;
  logic              irq;

  rd_item_t    sb_q[$];
  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 0;

  lvl_gpio_irq_ctrl #(.NPINS(NPINS), .AW(AW)) u_lvl_gpio_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mux_word  (mux_word),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a[AW-1:0];
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    bus_rd   = 1'b1;
    bus_addr = a[AW-1:0];
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops one expected item per sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          chk(bus_rdata, 32'hx, "scoreboard underflow");
        end else begin
          rd_item_t it;
          it = sb_q.pop_front();
          chk(bus_rdata, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wr    = 1'b0;
    bus_wdata = '0;
    bus_rd    = 1'b0;
    pin_in    = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk({20'd0, pin_out}, 32'd0, "R1 pin_out");
    chk({20'd0, pin_oe},  32'd0, "R1 pin_oe");
    chk(mux_word,         32'd0, "R1 mux_word");
    chk({31'd0, irq},     32'd0, "R1 irq");
    rd(OFS_DOUT,   0, "R1 dout");
    rd(OFS_DOE,    0, "R1 doe");
    rd(OFS_DIN,    0, "R1 din");
    rd(OFS_STAT,   0, "R1 stat");
    rd(OFS_POL_LO, 0, "R1 pol_lo");
    rd(OFS_IEN,    0, "R1 ien");
    rd(OFS_POL_HI, 0, "R1 pol_hi");
    rd(OFS_MUX,    0, "R1 mux");

    // R2 and R9 output registers
    wr(OFS_DOUT, 32'hFFFF_FFFF);
    rd(OFS_DOUT, 32'h0000_0FFF, "R2 R9 dout readback");
    chk({20'd0, pin_out}, 32'h0FFF, "R2 pin_out");
    wr(OFS_DOE, 32'h0000_05A5);
    rd(OFS_DOE, 32'h0000_05A5, "R2 doe readback");
    chk({20'd0, pin_oe}, 32'h05A5, "R2 pin_oe");

    // R8 mux word
    wr(OFS_MUX, 32'hDEAD_BEEF);
    rd(OFS_MUX, 32'hDEAD_BEEF, "R8 mux readback");
    chk(mux_word, 32'hDEAD_BEEF, "R8 mux_word");

    // R3 synchroniser latency: pin changes with the first of three reads
    pin_in = 12'h123;
    rd(OFS_DIN, 32'h000, "R3 din edge k");
    rd(OFS_DIN, 32'h000, "R3 din edge k+1");
    rd(OFS_DIN, 32'h123, "R3 din edge k+2");
    idle(2);
    // R5 and R7: latched while masked
    rd(OFS_STAT, 32'h123, "R5 status latched");
    chk({31'd0, irq}, 32'd0, "R7 masked irq low");

    // R6: clear while still active
    wr(OFS_STAT, 32'h003);
    rd(OFS_STAT, 32'h120, "R6 cleared for one cycle");
    rd(OFS_STAT, 32'h123, "R6 set again");

    // R5: writing zero has no effect; clear after source gone
    wr(OFS_STAT, 32'h000);
    rd(OFS_STAT, 32'h123, "R5 write zero no effect");
    pin_in = '0;
    idle(3);
    wr(OFS_STAT, 32'hFFFF_FFFF);
    rd(OFS_STAT, 32'h000, "R5 cleared");

    // R4 polarity fields with pins low
    wr(OFS_POL_LO, 32'h0000_0013);
    rd(OFS_POL_LO, 32'h0000_0011, "R4 pol_lo fields");
    rd(OFS_STAT,   32'h003, "R4 active-low pins 0 and 1");
    wr(OFS_POL_HI, 32'hFFFF_FFFF);
    rd(OFS_POL_HI, 32'h0000_1111, "R4 pol_hi fields");
    rd(OFS_STAT,   32'hF03, "R4 active-low pins 8 to 11");
    wr(OFS_POL_HI, 32'h0000_1000);
    rd(OFS_POL_HI, 32'h0000_1000, "R4 pin 11 only");
    wr(OFS_STAT, 32'hFFF);
    idle(1);
    rd(OFS_STAT, 32'h803, "R6 only active pins reassert");

    // R7 enable mask
    chk({31'd0, irq}, 32'd0, "R7 all masked");
    wr(OFS_IEN, 32'h002);
    chk({31'd0, irq}, 32'd1, "R7 pin 1 unmasked");
    wr(OFS_IEN, 32'h004);
    chk({31'd0, irq}, 32'd0, "R7 pin 2 not pending");
    wr(OFS_IEN, 32'hFFFF_F000);
    rd(OFS_IEN, 32'h000, "R9 ien upper bits ignored");
    chk({31'd0, irq}, 32'd0, "R7 irq after upper-only write");
    wr(OFS_IEN, 32'h800);
    chk({31'd0, irq}, 32'd1, "R7 pin 11 unmasked");
    pin_in = 12'h800;
    idle(3);
    wr(OFS_STAT, 32'h800);
    chk({31'd0, irq}, 32'd0, "R7 irq drops after clear of gone source");
    idle(1);
    chk({31'd0, irq}, 32'd0, "R6 no reassert when inactive");

    // R9 unmapped address
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20,    32'h0, "R9 unmapped reads zero");
    rd(OFS_DOUT, 32'hFFF, "R9 dout untouched");
    rd(OFS_DOE,  32'h5A5, "R9 doe untouched");

    // R10 read data holds
    idle(3);
    chk(bus_rdata, 32'h5A5, "R10 rdata hold");

    idle(2);
    chk(sb_q.size(), 0, "scoreboard drained");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule